// File: doc/BRIEF.md
# SATA Port Error and Active-Tag Status Registers

This block holds two status registers for one SATA host port, behind a plain 32-bit register read/write interface. The error register collects error events reported by the port's lower layers. Software acknowledges an error by writing 1 to its bit. Any of the four serious error classes raises a stop-transfer output, which the port's transfer engine uses to halt the current command. Recovered errors are recorded but do not halt anything.

The active-tag register tracks queued commands. Software sets a tag bit before it issues the matching queued command. Hardware clears tag bits when a device-bits notification reports those tags as complete. It also clears every tag bit when the port's start control falls, on a COMRESET and on a soft reset. Where hardware and software act on the same bit in one cycle, the outcome is fixed: a hardware clear beats a software set, and a hardware error event beats a software clear.

Top module: `sata_port_regs`

## Requirements
- R1: After reset both registers read 0 and `stopXfer` is 0.
- R2: Error register layout (offset 0x04, bits 15:0, bits 31:16 read 0). An `errEvt` pulse sets the matching bit on the next edge for these bits only: 11 internal bus error, 10 protocol error, 9 persistent link error, 8 transient data error, 1 recovered link error, 0 recovered data error. Bits 15:12 and 7:2 are never set and always read 0.
- R3: A write to offset 0x04 clears each implemented error bit whose data bit is 1. A data bit of 0 leaves the error bit unchanged.
- R4: If an error event and a clearing write hit the same bit in one cycle, the bit stays set.
- R5: A `phyNotReady` pulse sets error bit 1.
- R6: `stopXfer` is 1 exactly while any of error bits 11:8 is set. Bits 1:0 never assert it.
- R7: A write to the active-tag register (offset 0x08, 32 bits) ORs the data into the current value, so a 0 in the data never clears a tag bit.
- R8: When `devBitsValid` is 1, every tag bit that is set in `devBitsMask` is cleared on the next edge.
- R9: All tag bits clear on the next edge when `portStart` goes from 1 to 0, or when `comReset` or `softReset` is 1. A rising `portStart` clears nothing.
- R10: If a hardware clear and a software set hit the same tag bit in one cycle, the bit ends cleared.
- R11: `regRdata` shows the addressed register in the same cycle that `regRd` is 1. It is 0 when `regRd` is 0 or the address is neither 0x04 nor 0x08. Writes take effect on the next clock edge, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte address (0x04 error, 0x08 active tags) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| errEvt | input | 16 | Error event pulses, one per error bit position |
| phyNotReady | input | 1 | Link-layer PHY-not-ready pulse, sets error bit 1 |
| devBitsValid | input | 1 | Device-bits notification strobe |
| devBitsMask | input | 32 | Completed-tag mask of the notification |
| portStart | input | 1 | Port start control level |
| comReset | input | 1 | COMRESET event |
| softReset | input | 1 | Soft reset event |
| stopXfer | output | 1 | Halt request for the current transfer |

## Verification
Read data is due in the same cycle as the read strobe. Every write, event, notification and reset-type clear is due in the register one edge later. `stopXfer` follows the error register with no register of its own, so it changes in the cycle after the event or clearing write that caused the change. The bench drives stimulus just after a falling edge and samples 1 ns later. It compares both outputs against a behavioural model on every cycle, and updates that model only after the comparison, which reproduces the one-edge delay.

// File: rtl/port_regs_pkg.sv
package port_regs_pkg;
  localparam int ERR_W = 16;
  localparam logic [ERR_W-1:0] ERR_IMPL_MASK = 16'h0F03;
  localparam logic [ERR_W-1:0] ERR_HALT_MASK = 16'h0F00;
  localparam int PHY_NRDY_BIT = 1;

  typedef struct packed {
    logic errW1c;
    logic tagSet;
    logic tagClrAll;
    logic selErr;
    logic selTag;
  } regStrb_t;
endpackage

// File: rtl/port_regs_ctrl.sv
module port_regs_ctrl
  import port_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ERR_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] TAG_OFS = 8'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              portStart,
  input  logic              comReset,
  input  logic              softReset,
  output regStrb_t          strb
);
  logic prevStart;
  logic hitErr;
  logic hitTag;
  logic startFall;

  always_ff @(posedge clk) begin
    if (!rstN) prevStart <= 1'b0;
    else       prevStart <= portStart;
  end

  always_comb begin
    hitErr         = (regAddr == ERR_OFS);
    hitTag         = (regAddr == TAG_OFS);
    startFall      = prevStart && !portStart;
    strb.errW1c    = regWr && hitErr;
    strb.tagSet    = regWr && hitTag;
    strb.tagClrAll = startFall || comReset || softReset;
    strb.selErr    = regRd && hitErr;
    strb.selTag    = regRd && hitTag;
  end
endmodule

// File: rtl/port_regs_dp.sv
module port_regs_dp
  import port_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_N  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ERR_W-1:0]  errEvt,
  input  logic              phyNotReady,
  input  logic              devBitsValid,
  input  logic [TAG_N-1:0]  devBitsMask,
  output logic [DATA_W-1:0] rdata,
  output logic              stopXfer
);
  logic [ERR_W-1:0] errQ, errSet, errClr, errNext;
  logic [TAG_N-1:0] tagQ, tagSwSet, tagHwClr, tagNext;

  // Error register: events dominate software clears
  always_comb begin
    errSet  = (errEvt | (ERR_W'(phyNotReady) << PHY_NRDY_BIT)) & ERR_IMPL_MASK;
    errClr  = strb.errW1c ? (wdata[ERR_W-1:0] & ERR_IMPL_MASK) : '0;
    errNext = (errQ & ~errClr) | errSet;
  end

  // Active-tag register: hardware clears dominate software sets
  always_comb begin
    tagSwSet = strb.tagSet ? wdata[TAG_N-1:0] : '0;
    if (strb.tagClrAll)  tagHwClr = '1;
    else if (devBitsValid) tagHwClr = devBitsMask;
    else                 tagHwClr = '0;
    tagNext = (tagQ | tagSwSet) & ~tagHwClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ <= '0;
      tagQ <= '0;
    end else begin
      errQ <= errNext;
      tagQ <= tagNext;
    end
  end

  always_comb begin
    if (strb.selErr)      rdata = DATA_W'(errQ);
    else if (strb.selTag) rdata = DATA_W'(tagQ);
    else                  rdata = '0;
  end

  assign stopXfer = |(errQ & ERR_HALT_MASK);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (errQ & ~ERR_IMPL_MASK) == '0); // R2
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (errSet != '0) |=> ((errQ & $past(errSet)) == $past(errSet))); // R4
  AST_HW_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (tagHwClr != '0) |=> ((tagQ & $past(tagHwClr)) == '0)); // R10
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strb.tagClrAll |=> (tagQ == '0)); // R9
  AST_STOP_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopXfer) |-> $past(strb.errW1c)); // R6
endmodule

// File: rtl/sata_port_regs.sv
module sata_port_regs
  import port_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TAG_N  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [ERR_W-1:0]  errEvt,
  input  logic              phyNotReady,
  input  logic              devBitsValid,
  input  logic [TAG_N-1:0]  devBitsMask,
  input  logic              portStart,
  input  logic              comReset,
  input  logic              softReset,
  output logic              stopXfer
);
  regStrb_t strb;

  port_regs_ctrl #(
    .ADDR_W (ADDR_W),
    .ERR_OFS(ADDR_W'(4)),
    .TAG_OFS(ADDR_W'(8))
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .portStart(portStart),
    .comReset (comReset),
    .softReset(softReset),
    .strb     (strb)
  );

  port_regs_dp #(
    .DATA_W(DATA_W),
    .TAG_N (TAG_N)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wdata       (regWdata),
    .errEvt      (errEvt),
    .phyNotReady (phyNotReady),
    .devBitsValid(devBitsValid),
    .devBitsMask (devBitsMask),
    .rdata       (regRdata),
    .stopXfer    (stopXfer)
  );
endmodule

// File: tb/test_sata_port_regs.sv
`timescale 1ns/1ps
module test_sata_port_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 0, regRd = 0;
  logic [7:0]  regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic [15:0] errEvt = 0;
  logic        phyNotReady = 0, devBitsValid = 0;
  logic [31:0] devBitsMask = 0;
  logic        portStart = 0, comReset = 0, softReset = 0;
  logic        stopXfer;

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] mErr = 0;
  logic [31:0] mTag = 0;
  logic        mPrevStart = 0;
  bit          done = 0;

  localparam logic [7:0] A_ERR = 8'h04, A_TAG = 8'h08;

  always #2.5 clk = ~clk;

  sata_port_regs i_sata_port_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .errEvt(errEvt),
    .phyNotReady(phyNotReady), .devBitsValid(devBitsValid),
    .devBitsMask(devBitsMask), .portStart(portStart), .comReset(comReset),
    .softReset(softReset), .stopXfer(stopXfer)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Compare outputs with the model, advance the model, then wait a cycle
  task automatic tick(string tag);
    logic [31:0] expRd;
    logic [15:0] clr;
    #1;
    expRd = 0;
    if (regRd && regAddr == A_ERR) expRd = {16'h0, mErr};
    if (regRd && regAddr == A_TAG) expRd = mTag;
    checks++;
    if (regRdata !== expRd) begin
      errors++;
      $display("FAIL %s: regRdata actual=%h expected=%h", tag, regRdata, expRd);
    end
    checks++;
    if (stopXfer !== (mErr[11:8] != 0)) begin
      errors++;
      $display("FAIL %s: stopXfer actual=%b expected=%b", tag, stopXfer, mErr[11:8] != 0);
    end
    clr = (regWr && regAddr == A_ERR) ? regWdata[15:0] : 16'h0;
    for (int b = 0; b < 16; b++) begin
      bit impl = (b <= 1) || (b >= 8 && b <= 11);
      if (impl && clr[b]) mErr[b] = 1'b0;
      if (impl && errEvt[b]) mErr[b] = 1'b1;
    end
    if (phyNotReady) mErr[1] = 1'b1;
    if (comReset || softReset || (mPrevStart && !portStart)) mTag = 0;
    else begin
      if (regWr && regAddr == A_TAG) mTag = mTag | regWdata;
      if (devBitsValid) mTag = mTag & ~devBitsMask;
    end
    mPrevStart = portStart;
    @(negedge clk);
    regWr = 0; errEvt = 0; phyNotReady = 0; devBitsValid = 0;
    comReset = 0; softReset = 0; regWdata = 0; devBitsMask = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a);
    regRd = 1; regAddr = a; tick(tag);
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
    regRd = 1; regWr = 1; regAddr = a; regWdata = d; tick(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finishRun();
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    rd("R1", A_ERR); rd("R1", A_TAG);
    // R2: all event lines pulsed, only implemented bits land
    errEvt = 16'hFFFF; rd("R2", A_ERR);
    rd("R2", A_ERR); rd("R6", A_ERR);
    // R3: zero write is no-op, ones clear
    wr("R3", A_ERR, 32'h0); rd("R3", A_ERR);
    wr("R3", A_ERR, 32'h0100); rd("R6", A_ERR);
    wr("R6", A_ERR, 32'h0E00); rd("R6", A_ERR);
    // R4: event and clear on the same bit
    errEvt = 16'h0001; wr("R4", A_ERR, 32'h0001); rd("R4", A_ERR);
    errEvt = 16'h0400; wr("R4", A_ERR, 32'hFFFF_FFFF); rd("R4", A_ERR);
    wr("R3", A_ERR, 32'hFFFF_FFFF); rd("R3", A_ERR);
    // R5
    phyNotReady = 1; rd("R5", A_ERR); rd("R5", A_ERR);
    // R6: recovered errors alone do not halt
    errEvt = 16'h0001; rd("R6", A_ERR); rd("R6", A_ERR);
    wr("R3", A_ERR, 32'h3); rd("R3", A_ERR);
    // R7
    wr("R7", A_TAG, 32'h0000_00F0); wr("R7", A_TAG, 32'h0000_000F);
    wr("R7", A_TAG, 32'h0); rd("R7", A_TAG);
    // R8
    devBitsValid = 1; devBitsMask = 32'h11; rd("R8", A_TAG); rd("R8", A_TAG);
    // R10
    devBitsValid = 1; devBitsMask = 32'h100; wr("R10", A_TAG, 32'h8000_0100);
    rd("R10", A_TAG);
    comReset = 1; wr("R10", A_TAG, 32'h1); rd("R10", A_TAG);
    // R9: start rise keeps tags, fall clears them
    wr("R9", A_TAG, 32'hA5A5_0000);
    portStart = 1; rd("R9", A_TAG); rd("R9", A_TAG);
    wr("R9", A_TAG, 32'h3);
    portStart = 0; rd("R9", A_TAG); rd("R9", A_TAG);
    wr("R9", A_TAG, 32'hFFFF); comReset = 1; rd("R9", A_TAG); rd("R9", A_TAG);
    wr("R9", A_TAG, 32'hF0F0); softReset = 1; rd("R9", A_TAG); rd("R9", A_TAG);
    // R11: read strobe low, unmapped address, unmapped write
    wr("R11", A_TAG, 32'h77); errEvt = 16'h0200;
    regRd = 0; regAddr = A_TAG; tick("R11");
    regRd = 1; regAddr = 8'h0C; tick("R11");
    regWr = 1; regAddr = 8'h0C; regWdata = 32'hFFFF_FFFF; tick("R11");
    regWr = 1; regAddr = 8'h00; regWdata = 32'hFFFF_FFFF; tick("R11");
    rd("R11", A_TAG); rd("R11", A_ERR);
    wr("R11", A_ERR, 32'h0200); rd("R11", A_ERR);
    finishRun();
  end
endmodule